// File: doc/BRIEF.md
# Dual-Delay Keypress Read Window

This block takes one raw "some key is down" line from a keypad scanner and turns it into a short, active-low read enable for the key encoder. The line is fed to two delay paths. Both paths see the same signal. One path is quick to settle high and the other is slow. The encoder is allowed to read only while the quick path has settled high and the slow path has not. Bounce at the start of a press is therefore skipped, and the code is read once while the key is steady. Bounce at release cannot produce a second read.

Each path is a saturating up/down integrator. It is stepped by a divided system tick. It counts up at its own rate while the synchronised key line is high and down at its own rate while the line is low. Its output level uses hysteresis: the level rises at an upper count and falls only at a lower count. An arming flag closes the window for good once the slow path has risen. The flag opens it again only after both paths have returned low, so each press yields at most one window. Setting the tick divider and the thresholds places the delays in the few-millisecond range that contact bounce needs.

Top module: `keywin_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fast_lvl` and `slow_lvl` are 0 and `key_rd_n` is 1; both integrators start from zero.
- R2: `key_any` passes through a SYNC_STAGES-register synchroniser (default 2). The integrators and levels change only on a tick edge, which is one clock in TICK_DIV (default 4) counted from reset release.
- R3: On each tick, the fast integrator adds F_UP (default 4) when the synchronised line is 1 and subtracts F_DN (default 2) when it is 0. It saturates at F_MAX (default 16) and at 0. From saturation, releasing the key drops `fast_lvl` after exactly ceil((F_MAX-F_LO)/F_DN) = 6 ticks.
- R4: `fast_lvl` becomes 1 when the fast count reaches F_HI (default 12) or more. It becomes 0 when the count is F_LO (default 4) or less, and holds otherwise. A single-tick pulse on the line therefore leaves it at 0.
- R5: The slow integrator works the same way with S_UP=1, S_DN=1, S_MAX=40, S_HI=32, S_LO=8 as defaults, and drives `slow_lvl`.
- R6: `key_rd_n` is 0 exactly when `fast_lvl` is 1, `slow_lvl` is 0 and the window is armed.
- R7: The window is disarmed whenever `slow_lvl` is 1. It is re-armed only when `fast_lvl` and `slow_lvl` are both 0, so one press opens it at most once, even if the key bounces back during release.
- R8: If the line bounces while the fast count stays above F_LO, the window stays open without a break until `slow_lvl` rises.
- R9: A clean press and release moves (`fast_lvl`,`slow_lvl`) through 00, 10, 11, 01, 00, with `key_rd_n` low only in the 10 phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_any | input | 1 | Raw, unsynchronised "any key down" line, active high |
| key_rd_n | output | 1 | Encoder read enable, active low |
| fast_lvl | output | 1 | Level of the fast delay path |
| slow_lvl | output | 1 | Level of the slow delay path |

## Verification
The hardest case is a key that is released and then bounces back. In that case the fast path rises again while the slow path is still high, or is just falling. To reach it, the stimulus holds a press long enough to saturate the slow integrator. It then releases only until the fast count has drained, and presses again before the slow count reaches its lower threshold. The bench checks that no second window appears. A separate burst with a 3-high/1-low tick pattern keeps the fast count above its floor while the slow count climbs, to show that the window stretches rather than breaks. Random hold lengths are compared cycle by cycle against a reference model in the bench.

// File: rtl/keywin_gate.sv
module keywin_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 4,
  parameter int F_UP  = 4,
  parameter int F_DN  = 2,
  parameter int F_MAX = 16,
  parameter int F_HI  = 12,
  parameter int F_LO  = 4,
  parameter int S_UP  = 1,
  parameter int S_DN  = 1,
  parameter int S_MAX = 40,
  parameter int S_HI  = 32,
  parameter int S_LO  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic key_any,
  output logic key_rd_n,
  output logic fast_lvl,
  output logic slow_lvl
);
  localparam int FW = $clog2(F_MAX + 1);
  localparam int SW = $clog2(S_MAX + 1);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   key_s;
  logic [TW-1:0]          tdiv_q;
  logic                   tick;
  logic [FW-1:0]          fast_cnt, f_next;
  logic [SW-1:0]          slow_cnt, s_next;
  logic [FW:0]            f_sum;
  logic [SW:0]            s_sum;
  logic                   f_lvl_next, s_lvl_next, nf, ns;
  logic                   armed;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], key_any};
  end
  assign key_s = sync_q[SYNC_STAGES-1];

  assign tick = (tdiv_q == TW'(TICK_DIV - 1));
  always_ff @(posedge clk) begin
    if (rst)       tdiv_q <= '0;
    else if (tick) tdiv_q <= '0;
    else           tdiv_q <= tdiv_q + 1'b1;
  end

  assign f_sum  = {1'b0, fast_cnt} + (FW+1)'(F_UP);
  assign f_next = key_s
    ? ((f_sum > (FW+1)'(F_MAX)) ? FW'(F_MAX) : f_sum[FW-1:0])
    : ((fast_cnt > FW'(F_DN)) ? fast_cnt - FW'(F_DN) : '0);
  assign f_lvl_next = (f_next >= FW'(F_HI)) ? 1'b1 :
                      (f_next <= FW'(F_LO)) ? 1'b0 : fast_lvl;

  assign s_sum  = {1'b0, slow_cnt} + (SW+1)'(S_UP);
  assign s_next = key_s
    ? ((s_sum > (SW+1)'(S_MAX)) ? SW'(S_MAX) : s_sum[SW-1:0])
    : ((slow_cnt > SW'(S_DN)) ? slow_cnt - SW'(S_DN) : '0);
  assign s_lvl_next = (s_next >= SW'(S_HI)) ? 1'b1 :
                      (s_next <= SW'(S_LO)) ? 1'b0 : slow_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_cnt <= '0;
      fast_lvl <= 1'b0;
      slow_cnt <= '0;
      slow_lvl <= 1'b0;
    end else if (tick) begin
      fast_cnt <= f_next;
      fast_lvl <= f_lvl_next;
      slow_cnt <= s_next;
      slow_lvl <= s_lvl_next;
    end
  end

  assign nf = tick ? f_lvl_next : fast_lvl;
  assign ns = tick ? s_lvl_next : slow_lvl;

  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b1;
    else if (!nf && !ns) armed <= 1'b1;
    else if (ns)        armed <= 1'b0;
  end

  assign key_rd_n = ~(fast_lvl & ~slow_lvl & armed);
endmodule

module keywin_gate_chk #(
  parameter int F_MAX = 16,
  parameter int F_HI  = 12,
  parameter int F_LO  = 4,
  parameter int S_MAX = 40,
  parameter int S_HI  = 32,
  parameter int S_LO  = 8,
  localparam int FW = $clog2(F_MAX + 1),
  localparam int SW = $clog2(S_MAX + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [FW-1:0] fast_cnt,
  input logic [SW-1:0] slow_cnt,
  input logic          fast_lvl,
  input logic          slow_lvl,
  input logic          key_rd_n
);
  p_lvl_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(fast_lvl) && $stable(slow_lvl)));
  p_fast_cap_r3: assert property (@(posedge clk) disable iff (rst)
    fast_cnt <= FW'(F_MAX));
  p_fast_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (fast_cnt >= FW'(F_HI)) |-> fast_lvl);
  p_fast_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (fast_cnt <= FW'(F_LO)) |-> !fast_lvl);
  p_slow_cap_r5: assert property (@(posedge clk) disable iff (rst)
    slow_cnt <= SW'(S_MAX));
  p_slow_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (slow_cnt >= SW'(S_HI)) |-> slow_lvl);
  p_slow_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (slow_cnt <= SW'(S_LO)) |-> !slow_lvl);
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    !key_rd_n |-> (fast_lvl && !slow_lvl));
  p_no_reopen_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(slow_lvl) && fast_lvl) |-> key_rd_n);
endmodule

bind keywin_gate keywin_gate_chk #(
  .F_MAX(F_MAX), .F_HI(F_HI), .F_LO(F_LO),
  .S_MAX(S_MAX), .S_HI(S_HI), .S_LO(S_LO)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick),
  .fast_cnt(fast_cnt), .slow_cnt(slow_cnt),
  .fast_lvl(fast_lvl), .slow_lvl(slow_lvl), .key_rd_n(key_rd_n)
);

// File: tb/keywin_gate_test.sv
module keywin_gate_test;
  localparam int DIV = 4;
  localparam int FUP = 4, FDN = 2, FMX = 16, FHI = 12, FLO = 4;
  localparam int SUP = 1, SDN = 1, SMX = 40, SHI = 32, SLO = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_any = 1'b0;
  logic key_rd_n, fast_lvl, slow_lvl;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keywin_gate uut (.clk(clk), .rst(rst), .key_any(key_any),
                   .key_rd_n(key_rd_n), .fast_lvl(fast_lvl), .slow_lvl(slow_lvl));

  function automatic int integ(int c, bit up, int ur, int dr, int mx);
    if (up) return (c + ur > mx) ? mx : c + ur;
    return (c > dr) ? c - dr : 0;
  endfunction

  function automatic bit hyst(int c, bit cur, int hi, int lo);
    if (c >= hi) return 1'b1;
    if (c <= lo) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit m_s1, m_s2, m_fl, m_sl, m_arm, m_tick_last;
  int m_tc, m_fc, m_sc;

  always @(posedge clk) begin
    bit t, nfl, nsl;
    int nfc, nsc;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_tc <= 0; m_fc <= 0; m_sc <= 0;
      m_fl <= 0; m_sl <= 0; m_arm <= 1; m_tick_last <= 0;
    end else begin
      t = (m_tc == DIV - 1);
      nfc = m_fc; nsc = m_sc; nfl = m_fl; nsl = m_sl;
      if (t) begin
        nfc = integ(m_fc, m_s2, FUP, FDN, FMX);
        nsc = integ(m_sc, m_s2, SUP, SDN, SMX);
        nfl = hyst(nfc, m_fl, FHI, FLO);
        nsl = hyst(nsc, m_sl, SHI, SLO);
      end
      m_fc <= nfc; m_sc <= nsc; m_fl <= nfl; m_sl <= nsl;
      if (!nfl && !nsl) m_arm <= 1;
      else if (nsl)     m_arm <= 0;
      m_tick_last <= t;
      m_tc <= t ? 0 : m_tc + 1;
      m_s2 <= m_s1; m_s1 <= key_any;
    end
  end

  bit p_rd = 1, p_f = 0, p_s = 0;
  int opens = 0, stretch_breaks = 0;
  bit bounce_mode = 0;
  int seq [16];
  int seq_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 fast_lvl vs model", fast_lvl, m_fl);
      chk("R5 slow_lvl vs model", slow_lvl, m_sl);
      chk("R6 key_rd_n vs model", key_rd_n, !(m_fl && !m_sl && m_arm));
      if ((fast_lvl != p_f || slow_lvl != p_s) && !m_tick_last)
        chk("R2 level change off tick", 1, 0);
      if ((fast_lvl != p_f || slow_lvl != p_s) && seq_n < 16) begin
        seq[seq_n] = 2*int'(fast_lvl) + int'(slow_lvl);
        seq_n++;
      end
      if (p_rd && !key_rd_n) opens++;
      if (bounce_mode && fast_lvl && !slow_lvl && key_rd_n) stretch_breaks++;
    end
    p_rd = key_rd_n; p_f = fast_lvl; p_s = slow_lvl;
  end

  task automatic hold(bit v, int n);
    key_any = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic phase_start();
    hold(0, 400);
    opens = 0; seq_n = 1; seq[0] = 0; stretch_breaks = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0123));
    repeat (4) @(negedge clk);
    chk("R1 fast_lvl in reset", fast_lvl, 0);
    chk("R1 slow_lvl in reset", slow_lvl, 0);
    chk("R1 key_rd_n in reset", key_rd_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 key_rd_n after reset", key_rd_n, 1);

    // R9 / R7 clean press, then R3 saturation release timing
    phase_start();
    hold(1, 300);
    key_any = 0;
    n = 0;
    while (fast_lvl && n < 100) begin @(negedge clk); n++; end
    chk("R3 release cycles >= 23", int'(n >= 23), 1);
    chk("R3 release cycles <= 26", int'(n <= 26), 1);
    hold(0, 400);
    chk("R9 transitions", seq_n, 5);
    chk("R9 step1 10", seq[1], 2);
    chk("R9 step2 11", seq[2], 3);
    chk("R9 step3 01", seq[3], 1);
    chk("R9 step4 00", seq[4], 0);
    chk("R7 one window per clean press", opens, 1);

    // R4 single-tick glitch
    phase_start();
    hold(1, DIV);
    hold(0, 80);
    chk("R4 glitch leaves fast_lvl low", seq_n, 1);
    chk("R4 glitch opens no window", opens, 0);

    // R8 bounce with fast path held up
    phase_start();
    bounce_mode = 1;
    for (int i = 0; i < 60; i++) begin hold(1, 3*DIV); hold(0, DIV); end
    bounce_mode = 0;
    chk("R8 window never breaks before slow rises", stretch_breaks, 0);
    chk("R8 slow path reached", slow_lvl, 1);
    chk("R8 single window during bounce", opens, 1);

    // R7 release bounce after slow saturation
    phase_start();
    hold(1, 250);
    hold(0, 40);
    chk("R7 fast low after drain", fast_lvl, 0);
    chk("R7 slow still high", slow_lvl, 1);
    hold(1, 30);
    chk("R7 fast back up", fast_lvl, 1);
    hold(0, 400);
    chk("R7 no second window", opens, 1);

    // random segments
    for (int i = 0; i < 3000; i++) hold(1'($urandom_range(0, 1)), $urandom_range(1, 40));
    hold(0, 400);
    chk("R1 idle after random", key_rd_n, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule